// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for a configurable number of pins (71 by default). Pins are arranged in groups of 32, and each group has ten word registers. Software uses them to choose the direction of each pin. It changes output levels through load, OR-in and AND-out registers, reads the synchronized pin level, enables rising and falling edge detection per pin, and clears captured edge events.

Edge events collect in a sticky status vector. The status is cut into 16-pin interrupt banks. Each bank drives one interrupt line, and a separate bank-enable register gates that line. The register port is synchronous: a write takes effect on the clock edge where it is presented, and read data appears one cycle after the read request.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), `pin_out` is all 0, all edge enables, all status bits and the bank-enable register are 0, and every `irq` line is low. The direction register of a group reads all ones over its implemented pins.
- R2: Group g occupies byte addresses 0x10 + 0x28*g upward, with word registers in this order: direction, output data, set, clear, input, rising-enable set, rising-enable clear, falling-enable set, falling-enable clear, status. Pin p lives in group p/32 at bit p mod 32.
- R3: A direction bit of 1 makes the pin an input (`pin_oe` bit 0). A direction bit of 0 makes it an output (`pin_oe` bit 1).
- R4: A write to output data loads the output bits. A write to set drives the masked output bits to 1, and a write to clear drives them to 0; other bits keep their value. Reading set or clear returns the current output data.
- R5: The input register returns the pin level after a two-flop synchronizer, whatever the pin's direction. A read presented on the cycle a pin changes, or on the cycle after, still returns the old level; the third one returns the new level.
- R6: Writing 1s to rising-set or falling-set enables that polarity on the masked pins, and writing 1s to the matching clear register disables it. The two polarities are independent. Reading either register of a pair returns that polarity's enable vector.
- R7: A change between consecutive synchronized samples of an enabled polarity sets the pin's status bit. With both polarities enabled, both edges set it. An edge of a disabled polarity sets nothing.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An edge arriving on the same clock as its clear leaves the bit set.
- R9: Bank b covers pins 16*b to 16*b+15. Its line `irq[b]` is high while any status bit of the bank is set and bit b of the bank-enable register at byte address 0x08 is 1.
- R10: Register bits for pins at or above the pin count read 0 and ignore writes. Addresses that map to no register read 0.
- R11: `rdata` holds the value of the register addressed in the cycle before when `rd_en` was 1 in that cycle, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| pin_out | output | NUM_PINS | Output levels to the pads |
| pin_oe | output | NUM_PINS | Output enables, 1 drives the pad |
| irq | output | NUM_BANKS | One interrupt line per 16-pin bank |

## Verification
The bench builds the block with its default 71 pins. That gives three register groups with a last group of only seven pins, and five banks with a partial top bank. The masking of absent pins, the read-as-zero of their bits and the top bank's interrupt line can therefore all be exercised. A per-pin reference model follows every register and pin and is compared with the outputs each cycle. Directed sequences also probe the synchronizer delay, the independence of the two edge polarities, and the clear arriving on the same cycle as a new edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned REG_BYTES      = 4;
  localparam int unsigned REGS_PER_GROUP = 10;
  localparam int unsigned GROUP_PINS     = 32;
  localparam int unsigned BANK_PINS      = 16;
  localparam int unsigned GROUP_BASE     = 'h10;
  localparam int unsigned GROUP_STRIDE   = REGS_PER_GROUP * REG_BYTES;
  localparam int unsigned BANK_EN_ADDR   = 'h08;

  typedef enum logic [3:0] {
    RG_DIR      = 4'd0,
    RG_OUT      = 4'd1,
    RG_SET      = 4'd2,
    RG_CLR      = 4'd3,
    RG_IN       = 4'd4,
    RG_RISE_SET = 4'd5,
    RG_RISE_CLR = 4'd6,
    RG_FALL_SET = 4'd7,
    RG_FALL_CLR = 4'd8,
    RG_STAT     = 4'd9
  } grp_reg_e;

  typedef struct packed {
    logic     hit;
    grp_reg_e idx;
  } grp_sel_t;

  function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
    return (a + b - 1) / b;
  endfunction

  // Decode a byte address against register group g.
  function automatic grp_sel_t group_select(int unsigned a, int unsigned g);
    grp_sel_t    s;
    int unsigned base;
    int unsigned off;
    base  = GROUP_BASE + g * GROUP_STRIDE;
    s.hit = 1'b0;
    s.idx = RG_DIR;
    if (a >= base && a < base + GROUP_STRIDE && (a % REG_BYTES) == 0) begin
      off   = (a - base) / REG_BYTES;
      s.hit = 1'b1;
      s.idx = grp_reg_e'(4'(off));
    end
    return s;
  endfunction

  // Enabled transitions between the previous and current synchronized sample.
  function automatic logic [31:0] edge_events(logic [31:0] lvl, logic [31:0] prev,
                                              logic [31:0] ren, logic [31:0] fen);
    return (lvl & ~prev & ren) | (~lvl & prev & fen);
  endfunction

  // Sticky status: write-one clears, a new event wins over a clear.
  function automatic logic [31:0] sticky_update(logic [31:0] st, logic [31:0] clr,
                                                logic [31:0] evt);
    return (st & ~clr) | evt;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned N = 71
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prev
);

  logic [N-1:0] meta_q;
  logic [N-1:0] lvl_q;
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl  = lvl_q;
  assign prev = prev_q;

endmodule

// File: rtl/gpio_reg_group.sv
module gpio_reg_group
  import gpio_pkg::*;
#(
  parameter int unsigned GIDX   = 0,
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [WIDTH-1:0]  lvl,
  input  logic [WIDTH-1:0]  prev,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  status_q,
  output logic              rd_hit,
  output logic [31:0]       rd_val
);

  grp_sel_t         sel;
  logic             wr;
  logic [WIDTH-1:0] wd;
  logic [WIDTH-1:0] ren_q;
  logic [WIDTH-1:0] fen_q;
  logic [WIDTH-1:0] evt;
  logic [WIDTH-1:0] clr_mask;
  logic             unused_wdata;

  assign sel          = group_select(32'(addr), GIDX);
  assign wr           = wr_en & sel.hit;
  assign wd           = wdata[WIDTH-1:0];
  assign unused_wdata = ^wdata;

  assign evt      = WIDTH'(edge_events(32'(lvl), 32'(prev), 32'(ren_q), 32'(fen_q)));
  assign clr_mask = (wr && sel.idx == RG_STAT) ? wd : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q    <= '1;
      out_q    <= '0;
      ren_q    <= '0;
      fen_q    <= '0;
      status_q <= '0;
    end else begin
      if (wr) begin
        case (sel.idx)
          RG_DIR:      dir_q <= wd;
          RG_OUT:      out_q <= wd;
          RG_SET:      out_q <= out_q | wd;
          RG_CLR:      out_q <= out_q & ~wd;
          RG_RISE_SET: ren_q <= ren_q | wd;
          RG_RISE_CLR: ren_q <= ren_q & ~wd;
          RG_FALL_SET: fen_q <= fen_q | wd;
          RG_FALL_CLR: fen_q <= fen_q & ~wd;
          default:     ;
        endcase
      end
      status_q <= WIDTH'(sticky_update(32'(status_q), 32'(clr_mask), 32'(evt)));
    end
  end

  assign rd_hit = sel.hit;

  always_comb begin
    case (sel.idx)
      RG_DIR:                   rd_val = 32'(dir_q);
      RG_OUT, RG_SET, RG_CLR:   rd_val = 32'(out_q);
      RG_IN:                    rd_val = 32'(lvl);
      RG_RISE_SET, RG_RISE_CLR: rd_val = 32'(ren_q);
      RG_FALL_SET, RG_FALL_CLR: rd_val = 32'(fen_q);
      RG_STAT:                  rd_val = 32'(status_q);
      default:                  rd_val = '0;
    endcase
  end

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 71,
  parameter int unsigned NUM_BANKS = 5
) (
  input  logic [NUM_PINS-1:0]  status_all,
  input  logic [NUM_BANKS-1:0] bank_en,
  output logic [NUM_BANKS-1:0] irq
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned LO = b * BANK_PINS;
    localparam int unsigned BW = (NUM_PINS - LO >= BANK_PINS) ? BANK_PINS : NUM_PINS - LO;
    assign irq[b] = bank_en[b] & (|status_all[LO +: BW]);
  end

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 71,
  parameter int unsigned NUM_BANKS = ceil_div(NUM_PINS, BANK_PINS),
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [NUM_PINS-1:0]  pin_in,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [NUM_PINS-1:0]  pin_oe,
  output logic [NUM_BANKS-1:0] irq
);

  localparam int unsigned NUM_GROUPS = ceil_div(NUM_PINS, GROUP_PINS);

  logic [NUM_PINS-1:0]   lvl;
  logic [NUM_PINS-1:0]   prev;
  logic [NUM_PINS-1:0]   dir_all;
  logic [NUM_PINS-1:0]   status_all;
  logic [NUM_BANKS-1:0]  bank_en_q;
  logic [NUM_GROUPS-1:0] grp_hit;
  logic [31:0]           grp_rd [NUM_GROUPS];
  logic [31:0]           rd_mux;
  logic                  ben_sel;

  gpio_sync #(.N(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_in (pin_in),
    .lvl    (lvl),
    .prev   (prev)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int unsigned LO = g * GROUP_PINS;
    localparam int unsigned W  = (NUM_PINS - LO >= GROUP_PINS) ? GROUP_PINS : NUM_PINS - LO;
    gpio_reg_group #(
      .GIDX   (g),
      .WIDTH  (W),
      .ADDR_W (ADDR_W)
    ) u_grp (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .lvl      (lvl[LO +: W]),
      .prev     (prev[LO +: W]),
      .dir_q    (dir_all[LO +: W]),
      .out_q    (pin_out[LO +: W]),
      .status_q (status_all[LO +: W]),
      .rd_hit   (grp_hit[g]),
      .rd_val   (grp_rd[g])
    );
  end

  assign pin_oe  = ~dir_all;
  assign ben_sel = (32'(addr) == BANK_EN_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_en_q <= '0;
    end else if (wr_en && ben_sel) begin
      bank_en_q <= wdata[NUM_BANKS-1:0];
    end
  end

  always_comb begin
    rd_mux = ben_sel ? 32'(bank_en_q) : 32'd0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grp_hit[g]) rd_mux = rd_mux | grp_rd[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd_en ? rd_mux : 32'd0;
    end
  end

  gpio_bank_irq #(
    .NUM_PINS  (NUM_PINS),
    .NUM_BANKS (NUM_BANKS)
  ) u_irq (
    .status_all (status_all),
    .bank_en    (bank_en_q),
    .irq        (irq)
  );

endmodule

// File: rtl/gpio_ctrl_checker.sv
module gpio_ctrl_checker
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 71,
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [31:0]          wdata,
  input logic [31:0]          rdata,
  input logic [NUM_PINS-1:0]  pin_out,
  input logic [NUM_PINS-1:0]  pin_oe,
  input logic [NUM_BANKS-1:0] irq,
  input logic [NUM_PINS-1:0]  status_all,
  input logic [NUM_BANKS-1:0] bank_en_q
);

  localparam int unsigned NG       = ceil_div(NUM_PINS, GROUP_PINS);
  localparam int unsigned LAST_W   = NUM_PINS - (NG - 1) * GROUP_PINS;
  localparam int unsigned LAST_DIR = GROUP_BASE + (NG - 1) * GROUP_STRIDE;
  localparam int unsigned SET0     = GROUP_BASE + 2 * REG_BYTES;
  localparam int unsigned CLR0     = GROUP_BASE + 3 * REG_BYTES;

  assert_oe_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0));

  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == 32'd0));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (bank_en_q == '0) |-> (irq == '0));

  assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (rst)
    (status_all == '0) |-> (irq == '0));

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (|($past(status_all) & ~status_all)) |-> $past(wr_en));

  if (NUM_PINS >= GROUP_PINS) begin : g_full0
    assert_set_mask_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && 32'(addr) == SET0) |=> ((pin_out[31:0] & $past(wdata)) == $past(wdata)));

    assert_clr_mask_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && 32'(addr) == CLR0) |=> ((pin_out[31:0] & $past(wdata)) == 32'd0));
  end

  if (LAST_W < GROUP_PINS) begin : g_partial
    assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (rst)
      (rd_en && 32'(addr) == LAST_DIR) |=> (rdata[31:LAST_W] == '0));
  end

endmodule

bind gpio_ctrl gpio_ctrl_checker #(
  .NUM_PINS  (NUM_PINS),
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .irq        (irq),
  .status_all (status_all),
  .bank_en_q  (bank_en_q)
);

// File: tb/gpio_ctrl_test.sv
`timescale 1ns/1ps
module gpio_ctrl_test;

  localparam int NP = 71;
  localparam int NB = 5;
  localparam int NG = (NP + 31) / 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [NP-1:0] pin_in = '0;
  wire  [31:0]   rdata;
  wire  [NP-1:0] pin_out;
  wire  [NP-1:0] pin_oe;
  wire  [NB-1:0] irq;

  always #2 clk = ~clk;

  gpio_ctrl #(.NUM_PINS(NP)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_wide(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model, one pin at a time ----------------
  logic [NP-1:0] m_dir, m_out, m_ren, m_fen, m_st, m_s1, m_s2, m_s3;
  logic [NB-1:0] m_ben;
  logic [31:0]   m_rdata;

  function automatic int reg_of(int a);
    int g;
    if (a < 16 || (a % 4) != 0) return -1;
    g = (a - 16) / 40;
    if (g >= NG) return -1;
    return g * 16 + ((a - 16) % 40) / 4;
  endfunction

  function automatic logic [31:0] model_read(int a);
    logic [31:0] v;
    int r, g, k, p;
    v = '0;
    if (a == 8) return 32'(m_ben);
    r = reg_of(a);
    if (r < 0) return '0;
    g = r / 16;
    k = r % 16;
    for (int j = 0; j < 32; j++) begin
      p = g * 32 + j;
      if (p < NP) begin
        case (k)
          0:       v[j] = m_dir[p];
          1, 2, 3: v[j] = m_out[p];
          4:       v[j] = m_s2[p];
          5, 6:    v[j] = m_ren[p];
          7, 8:    v[j] = m_fen[p];
          9:       v[j] = m_st[p];
          default: v[j] = 1'b0;
        endcase
      end
    end
    return v;
  endfunction

  always @(posedge clk) begin : model_blk
    logic [31:0]   rv;
    logic [NP-1:0] evt, clr;
    int r, g, k, p;
    if (rst) begin
      m_dir = '1; m_out = '0; m_ren = '0; m_fen = '0; m_st = '0;
      m_s1 = '0; m_s2 = '0; m_s3 = '0; m_ben = '0; m_rdata = '0;
    end else begin
      rv = rd_en ? model_read(int'(addr)) : 32'd0;
      for (int q = 0; q < NP; q++)
        evt[q] = (m_s2[q] & ~m_s3[q] & m_ren[q]) | (~m_s2[q] & m_s3[q] & m_fen[q]);
      clr = '0;
      if (wr_en) begin
        if (int'(addr) == 8) m_ben = wdata[NB-1:0];
        r = reg_of(int'(addr));
        if (r >= 0) begin
          g = r / 16;
          k = r % 16;
          for (int j = 0; j < 32; j++) begin
            p = g * 32 + j;
            if (p < NP) begin
              case (k)
                0: m_dir[p] = wdata[j];
                1: m_out[p] = wdata[j];
                2: if (wdata[j]) m_out[p] = 1'b1;
                3: if (wdata[j]) m_out[p] = 1'b0;
                5: if (wdata[j]) m_ren[p] = 1'b1;
                6: if (wdata[j]) m_ren[p] = 1'b0;
                7: if (wdata[j]) m_fen[p] = 1'b1;
                8: if (wdata[j]) m_fen[p] = 1'b0;
                9: clr[p] = wdata[j];
                default: ;
              endcase
            end
          end
        end
      end
      m_st    = (m_st & ~clr) | evt;
      m_s3    = m_s2;
      m_s2    = m_s1;
      m_s1    = pin_in;
      m_rdata = rv;
    end
  end

  always @(negedge clk) begin : compare_blk
    logic [NB-1:0] eirq;
    if (!rst && !done) begin
      for (int b = 0; b < NB; b++) begin
        eirq[b] = 1'b0;
        for (int q = b * 16; q < b * 16 + 16 && q < NP; q++)
          if (m_st[q]) eirq[b] = m_ben[b];
      end
      check_wide("R3 model pin_oe", pin_oe, ~m_dir);
      check_wide("R4 model pin_out", pin_out, m_out);
      check("R9 model irq", 32'(irq), 32'(eirq));
      check("R11 model rdata", rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic wr(int a, logic [31:0] d);
    addr  = AW'(a);
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr  = AW'(a);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      finish_run();
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    rd('h10, d); check("R1 dir g0 reset", d, 32'hFFFF_FFFF);
    rd('h60, d); check("R1 dir g2 reset (R10 upper bits 0)", d, 32'h0000_007F);
    check_wide("R1 pin_oe reset", pin_oe, '0);
    check_wide("R1 pin_out reset", pin_out, '0);
    check("R1 irq reset", 32'(irq), 32'd0);
    rd('h08, d); check("R1 bank enable reset", d, 32'd0);
    rd('h34, d); check("R1 status reset", d, 32'd0);

    // R3 direction
    wr('h10, 32'hFFFF_0000);
    check("R3 low half outputs", pin_oe[31:0], 32'h0000_FFFF);

    // R4 set / clear / load
    wr('h18, 32'h0000_00F0); check("R4 set", pin_out[31:0], 32'h0000_00F0);
    wr('h1C, 32'h0000_0030); check("R4 clear", pin_out[31:0], 32'h0000_00C0);
    rd('h18, d); check("R4 set reads output", d, 32'h0000_00C0);
    wr('h3C, 32'h1234_5678); check("R4 load g1", pin_out[63:32], 32'h1234_5678);
    rd('h44, d); check("R4 clear reads output", d, 32'h1234_5678);

    // R2 mapping: pin 45 is group 1 bit 13
    wr('h40, 32'h0000_2000);
    check("R2 pin45 set", 32'(pin_out[45]), 32'd1);

    // R5 synchronized input
    pin_in[63:32] = 32'hA5A5_0F0F;
    tick(3);
    rd('h48, d); check("R5 input g1", d, 32'hA5A5_0F0F);
    pin_in[0] = 1'b1;
    rd('h20, d); check("R5 first read old level", d, 32'd0);
    rd('h20, d); check("R5 second read old level", d, 32'd0);
    rd('h20, d); check("R5 third read new level on output pin", d, 32'd1);

    // R6 edge enables
    wr('h24, 32'h3);
    wr('h2C, 32'h2);
    rd('h28, d); check("R6 rising enables", d, 32'h3);
    rd('h30, d); check("R6 falling enables", d, 32'h2);
    wr('h28, 32'h1);
    rd('h24, d); check("R6 rising clear", d, 32'h2);
    rd('h2C, d); check("R6 falling untouched", d, 32'h2);

    // R7 edge detection
    pin_in[0] = 1'b0; tick(4);
    rd('h34, d); check("R7 disabled polarity ignored", d, 32'h0);
    pin_in[1] = 1'b1; tick(4);
    rd('h34, d); check("R7 rising edge", d, 32'h2);

    // R8 write-one-to-clear
    wr('h34, 32'h0);
    rd('h34, d); check("R8 write zero keeps", d, 32'h2);
    wr('h34, 32'h2);
    rd('h34, d); check("R8 write one clears", d, 32'h0);
    pin_in[1] = 1'b0; tick(4);
    rd('h34, d); check("R7 falling edge with both enabled", d, 32'h2);
    wr('h34, 32'h2);
    pin_in[1] = 1'b1; tick(2);
    wr('h34, 32'h2);
    rd('h34, d); check("R8 edge wins over clear", d, 32'h2);
    wr('h34, 32'h2);
    rd('h34, d); check("R8 cleared", d, 32'h0);

    // R9 bank interrupts
    wr('h24, 32'h0010_0000);
    pin_in[20] = 1'b1; tick(4);
    check("R9 gated by bank enable", 32'(irq), 32'd0);
    wr('h08, 32'h1F);
    check("R9 bank1 high", 32'(irq), 32'b00010);
    rd('h08, d); check("R9 bank enable readback", d, 32'h1F);
    wr('h34, 32'h0010_0000);
    check("R9 low after clear", 32'(irq), 32'd0);
    wr('h7C, 32'h4);
    pin_in[66] = 1'b1; tick(4);
    pin_in[66] = 1'b0; tick(4);
    check("R9 top bank high", 32'(irq), 32'b10000);
    rd('h84, d); check("R9 g2 status", d, 32'h4);
    wr('h84, 32'h4);
    check("R9 top bank low", 32'(irq), 32'd0);

    // R10 unimplemented bits and addresses
    wr('h68, 32'hFFFF_FFFF);
    check("R10 g2 outputs", 32'(pin_out[70:64]), 32'h7F);
    rd('h6C, d); check("R10 g2 upper bits read 0", d, 32'h0000_007F);
    rd('h88, d); check("R10 unmapped past end", d, 32'd0);
    rd('h04, d); check("R10 unmapped below", d, 32'd0);
    wr('h60, 32'h0);
    check("R10 g2 outputs enabled", 32'(pin_oe[70:64]), 32'h7F);
    rd('h60, d); check("R3 g2 direction", d, 32'd0);

    // R11 idle read data
    tick(1);
    check("R11 rdata idle", rdata, 32'd0);

    tick(2);
    done = 1'b1;
    finish_run();
  end

endmodule